// File: doc/BRIEF.md
# SPI Register-File Access Slave

This block is an SPI slave that lets a host read and write a bank of up to 64 byte-addressed register files. Each transaction begins with a header of one or two octets. The first octet carries the direction, a flag saying whether an offset octet follows, and the number of the file. When the offset octet is present, its low seven bits give the starting byte within the file. Without it, the transfer starts at byte zero. Every octet after the header is a body octet, read from or written to consecutive byte positions.

File 0 lives inside the block. It is a read-only 32-bit identity word, and it is sent with its lowest-order octet first. The other files sit behind a byte-wide internal port, which is driven from the block's registered file number and byte index. On that port the block receives each file's read data, its size in bytes and a read-only flag. It emits a one-cycle write strobe for every accepted body octet. SCLK, MOSI and chip select are oversampled by a faster system clock, and their edges are detected in that domain.

Top module: `spi_regfile_slave`

## Requirements
- R1: Bit 7 of the first header octet selects the direction (1 = write, 0 = read). Bits 5:0 select the file number driven on `rf_id`.
- R2: When bit 6 of the first octet is 0, the body starts at byte 0. When it is 1, a second octet follows, and its bits 6:0 (with bit 7 = 0) give the starting byte.
- R3: SPI mode 0 is used, most significant bit first. The first bit of every read body octet is valid on MISO before the first SCLK rising edge of that octet.
- R4: File 0 reads back the word 0xDECA0130 lowest octet first: 0x30, 0x01, 0xCA, 0xDE.
- R5: The byte index advances by one after each body octet, on both reads and writes. This includes writes that are discarded.
- R6: Each accepted write body octet produces exactly one `rf_wr_en` pulse, one clock wide. During the pulse, `rf_id`, `rf_idx` and `rf_wdata` hold the file, the byte and the data.
- R7: Writes to file 0, or to any file for which `rf_ro` is 1, produce no strobe.
- R8: A read at a byte index at or beyond the file's length returns 0x00. The length is 4 for file 0 and `rf_size` for the other files.
- R9: MISO is 0 during header octets, during write bodies and while chip select is high.
- R10: A second header octet with bit 7 set raises `err`. The rest of that transaction then causes no write and leaves MISO at 0. `err` clears when chip select next goes low.
- R11: Raising chip select in the middle of an octet discards the partial octet. The next transaction is parsed from its first header octet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock |
| mosi | input | 1 | SPI data from the host |
| cs_n | input | 1 | SPI chip select, active low |
| miso | output | 1 | SPI data to the host |
| err | output | 1 | Unsupported extended header seen |
| rf_id | output | 6 | Selected file number |
| rf_idx | output | 7 | Current byte index in the file |
| rf_rdata | input | 8 | Read byte of file `rf_id` at `rf_idx` |
| rf_size | input | 8 | Length in bytes of file `rf_id` |
| rf_ro | input | 1 | File `rf_id` is read-only |
| rf_wr_en | output | 1 | One-clock write strobe |
| rf_wdata | output | 8 | Write data byte |

## Verification
The identity file is read in three ways: without an index, with an index near its end, and past its end. Together these separate octet ordering, the use of the offset and the zero fill. Writable files are written both with and without an offset, then read back across their length limit, which shows whether the index advances on writes and on reads. Writes to the internal file and to a file marked read-only confirm that the strobe is suppressed while the index keeps moving. An extended header and an aborted partial octet show that the parser recovers cleanly when chip select is raised.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

    localparam int FID_W  = 6;
    localparam int IDX_W  = 7;
    localparam int SIZE_W = IDX_W + 1;

    typedef enum logic [2:0] {
        PH_HDR0 = 3'd0,
        PH_HDR1 = 3'd1,
        PH_RD   = 3'd2,
        PH_WR   = 3'd3,
        PH_SKIP = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [2:0]         bit_cnt;
        logic [7:0]         rx;
        logic [7:0]         tx;
        logic               load_pend;
        logic               wr_mode;
        logic [FID_W-1:0]   fid;
        logic [IDX_W-1:0]   idx;
        logic               wr_en;
        logic [7:0]         wdata;
        logic               err;
        logic               sclk_prev;
        logic               cs_prev;
    } ctl_s;

endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [63:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = d;
        end else begin : g_next
            assign stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= RST_VAL[WIDTH-1:0];
            end else begin
                stage_q[s] <= stage_d;
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_rf_rdsel.sv
module spi_rf_rdsel
    import spi_rf_pkg::*;
#(
    parameter int              ID_BYTES = 4,
    parameter logic [ID_BYTES*8-1:0] ID_WORD = 32'hDECA0130
) (
    input  logic [FID_W-1:0]  fid,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        ext_rdata,
    input  logic [SIZE_W-1:0] ext_size,
    output logic [7:0]        rd_byte
);

    localparam int SEL_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

    logic [7:0] id_tbl [ID_BYTES];

    for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
        assign id_tbl[g] = ID_WORD[8*g +: 8];
    end

    logic [SIZE_W-1:0] idx_ext;
    assign idx_ext = {1'b0, idx};

    always_comb begin
        rd_byte = 8'h00;
        if (fid == '0) begin
            if (idx_ext < SIZE_W'(ID_BYTES)) begin
                rd_byte = id_tbl[idx[SEL_W-1:0]];
            end
        end else if (idx_ext < ext_size) begin
            rd_byte = ext_rdata;
        end
    end

endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
    import spi_rf_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          ID_BYTES    = 4,
    parameter logic [31:0] ID_WORD     = 32'hDECA0130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              cs_n,
    output logic              miso,
    output logic              err,
    output logic [FID_W-1:0]  rf_id,
    output logic [IDX_W-1:0]  rf_idx,
    input  logic [7:0]        rf_rdata,
    input  logic [SIZE_W-1:0] rf_size,
    input  logic              rf_ro,
    output logic              rf_wr_en,
    output logic [7:0]        rf_wdata
);

    localparam int IN_W = 3;

    logic [IN_W-1:0] pins_raw;
    logic [IN_W-1:0] pins_s;
    logic            sclk_s;
    logic            mosi_s;
    logic            cs_s;

    assign pins_raw = {cs_n, mosi, sclk};

    spi_rf_sync #(
        .WIDTH   (IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (64'd4)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    assign sclk_s = pins_s[0];
    assign mosi_s = pins_s[1];
    assign cs_s   = pins_s[2];

    ctl_s st_q;
    ctl_s st_d;

    logic [7:0] rd_byte;

    spi_rf_rdsel #(
        .ID_BYTES (ID_BYTES),
        .ID_WORD  (ID_WORD)
    ) rdsel_i (
        .fid       (st_q.fid),
        .idx       (st_q.idx),
        .ext_rdata (rf_rdata),
        .ext_size  (rf_size),
        .rd_byte   (rd_byte)
    );

    logic       rise;
    logic       fall;
    logic       cs_fall;
    logic       ro_sel;
    logic [7:0] byte_in;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        rise       = sclk_s & ~st_q.sclk_prev;
        fall       = ~sclk_s & st_q.sclk_prev;
        cs_fall    = st_q.cs_prev & ~cs_s;
        ro_sel     = (st_q.fid == '0) | rf_ro;
        byte_in    = {st_q.rx[6:0], mosi_s};

        st_d.sclk_prev = sclk_s;
        st_d.cs_prev   = cs_s;

        // index step after an issued write strobe
        if (st_q.wr_en) begin
            st_d.idx = st_q.idx + 1'b1;
        end

        if (cs_s) begin
            st_d.phase     = PH_HDR0;
            st_d.bit_cnt   = '0;
            st_d.tx        = '0;
            st_d.load_pend = 1'b0;
        end else begin
            if (cs_fall) begin
                st_d.err = 1'b0;
            end
            if (rise) begin
                st_d.rx      = byte_in;
                st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                if (st_q.bit_cnt == 3'd7) begin
                    st_d.load_pend = 1'b1;
                    unique case (st_q.phase)
                        PH_HDR0: begin
                            st_d.fid     = byte_in[5:0];
                            st_d.wr_mode = byte_in[7];
                            st_d.idx     = '0;
                            if (byte_in[6]) begin
                                st_d.phase = PH_HDR1;
                            end else begin
                                st_d.phase = byte_in[7] ? PH_WR : PH_RD;
                            end
                        end
                        PH_HDR1: begin
                            if (byte_in[7]) begin
                                st_d.phase = PH_SKIP;
                                st_d.err   = 1'b1;
                            end else begin
                                st_d.idx   = byte_in[6:0];
                                st_d.phase = st_q.wr_mode ? PH_WR : PH_RD;
                            end
                        end
                        PH_RD: begin
                            st_d.idx = st_q.idx + 1'b1;
                        end
                        PH_WR: begin
                            if (ro_sel) begin
                                st_d.idx = st_q.idx + 1'b1;
                            end else begin
                                st_d.wr_en = 1'b1;
                                st_d.wdata = byte_in;
                            end
                        end
                        default: begin
                        end
                    endcase
                end
            end
            if (fall) begin
                if (st_q.load_pend) begin
                    st_d.load_pend = 1'b0;
                    st_d.tx        = (st_q.phase == PH_RD) ? rd_byte : 8'h00;
                end else begin
                    st_d.tx = {st_q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.phase     <= PH_HDR0;
            st_q.cs_prev   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso     = st_q.tx[7];
    assign err      = st_q.err;
    assign rf_id    = st_q.fid;
    assign rf_idx   = st_q.idx;
    assign rf_wr_en = st_q.wr_en;
    assign rf_wdata = st_q.wdata;

endmodule

// File: rtl/spi_rf_checker.sv
module spi_rf_checker
    import spi_rf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             miso,
    input logic             err,
    input logic             rf_wr_en,
    input logic [FID_W-1:0] rf_id,
    input logic [IDX_W-1:0] rf_idx,
    input phase_e           phase,
    input logic             cs_s
);

    p_quiet_miso_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_RD) |-> !miso);

    p_idle_miso_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso);

    p_ro_file0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (rf_id != '0));

    p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> !rf_wr_en);

    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> (rf_idx == $past(rf_idx) + 7'd1));

    p_err_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !rf_wr_en);

    p_skip_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP) |-> err);

endmodule

bind spi_regfile_slave spi_rf_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .miso     (miso),
    .err      (err),
    .rf_wr_en (rf_wr_en),
    .rf_id    (rf_id),
    .rf_idx   (rf_idx),
    .phase    (st_q.phase),
    .cs_s     (cs_s)
);

// File: tb/spi_regfile_slave_tb_top.sv
module spi_regfile_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       cs_n = 1'b1;
    logic       miso;
    logic       err;
    logic [5:0] rf_id;
    logic [6:0] rf_idx;
    logic [7:0] rf_rdata;
    logic [7:0] rf_size;
    logic       rf_ro;
    logic       rf_wr_en;
    logic [7:0] rf_wdata;

    int nchk  = 0;
    int nfail = 0;

    logic [7:0]  mem [0:3][0:127];
    logic [7:0]  txb [$];
    logic [7:0]  rxb [$];
    logic [20:0] exp_wr [$];
    logic        err_start;
    logic        err_end;
    int          idle_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] fsize(input logic [5:0] f);
        case (f)
            6'd1:    return 8'd16;
            6'd2:    return 8'd8;
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [5:0] f, input logic [6:0] i);
        logic [31:0] idw;
        idw = 32'hDECA0130;
        if (f == 6'd0) return (i < 7'd4) ? idw[8*i +: 8] : 8'h00;
        return ({1'b0, i} < fsize(f)) ? mem[f[1:0]][i] : 8'h00;
    endfunction

    assign rf_rdata = mem[rf_id[1:0]][rf_idx];
    assign rf_size  = fsize(rf_id);
    assign rf_ro    = (rf_id == 6'd2);

    spi_regfile_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n),
        .miso     (miso),
        .err      (err),
        .rf_id    (rf_id),
        .rf_idx   (rf_idx),
        .rf_rdata (rf_rdata),
        .rf_size  (rf_size),
        .rf_ro    (rf_ro),
        .rf_wr_en (rf_wr_en),
        .rf_wdata (rf_wdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock model of the write port and the idle line
    always @(negedge clk) begin
        if (rst_n) begin
            if (rf_wr_en) begin
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R7 unexpected write strobe", {11'd0, rf_id, rf_idx, rf_wdata}, 32'd0);
                end else begin
                    logic [20:0] e;
                    e = exp_wr.pop_front();
                    chk({rf_id, rf_idx, rf_wdata} == e, "R6 write strobe content",
                        {11'd0, rf_id, rf_idx, rf_wdata}, {11'd0, e});
                end
                mem[rf_id[1:0]][rf_idx] = rf_wdata;
            end
            idle_cnt = cs_n ? idle_cnt + 1 : 0;
            if (idle_cnt > 4) begin
                chk(miso == 1'b0 && rf_wr_en == 1'b0, "R9 idle outputs", {30'd0, miso, rf_wr_en}, 32'd0);
            end
        end
    end

    task automatic spi_txn(input int abort_bits);
        rxb.delete();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        err_start = err;
        if (abort_bits > 0) begin
            for (int b = 7; b > 7 - abort_bits; b--) begin
                mosi = txb[0][b];
                repeat (HALF) @(negedge clk);
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
        end else begin
            foreach (txb[k]) begin
                logic [7:0] r;
                for (int b = 7; b >= 0; b--) begin
                    mosi = txb[k][b];
                    repeat (HALF) @(negedge clk);
                    r[b] = miso;
                    sclk = 1'b1;
                    repeat (HALF) @(negedge clk);
                    sclk = 1'b0;
                end
                rxb.push_back(r);
            end
        end
        repeat (HALF) @(negedge clk);
        err_end = err;
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic do_read(input logic [5:0] f, input bit indexed, input logic [6:0] off,
                           input int n, input string req);
        int hdr;
        logic [6:0] start;
        logic [7:0] exp [$];
        hdr   = indexed ? 2 : 1;
        start = indexed ? off : 7'd0;
        txb.delete();
        txb.push_back({1'b0, indexed, f});
        if (indexed) txb.push_back({1'b0, off});
        for (int k = 0; k < n; k++) begin
            txb.push_back(8'hA5);
            exp.push_back(exp_rd(f, start + 7'(k)));
        end
        spi_txn(0);
        for (int k = 0; k < hdr; k++) chk(rxb[k] == 8'h00, "R9 miso in header", {24'd0, rxb[k]}, 32'd0);
        for (int k = 0; k < n; k++) chk(rxb[hdr+k] == exp[k], req, {24'd0, rxb[hdr+k]}, {24'd0, exp[k]});
    endtask

    task automatic do_write(input logic [5:0] f, input bit indexed, input logic [6:0] off,
                            input int n, input logic [7:0] seed);
        logic [6:0] start;
        start = indexed ? off : 7'd0;
        txb.delete();
        txb.push_back({1'b1, indexed, f});
        if (indexed) txb.push_back({1'b0, off});
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = seed + 8'(k * 37);
            txb.push_back(d);
            if (f != 6'd0 && f != 6'd2) exp_wr.push_back({f, start + 7'(k), d});
        end
        spi_txn(0);
        foreach (rxb[k]) chk(rxb[k] == 8'h00, "R9 miso during write", {24'd0, rxb[k]}, 32'd0);
        chk(exp_wr.size() == 0, "R6 all writes issued", exp_wr.size(), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        for (int f = 0; f < 4; f++)
            for (int i = 0; i < 128; i++)
                mem[f][i] = 8'(f * 16 + i) ^ 8'h5A;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(miso == 1'b0, "R9 reset miso", {31'd0, miso}, 32'd0);
        chk(err == 1'b0, "R10 reset err", {31'd0, err}, 32'd0);
        chk(rf_wr_en == 1'b0, "R6 reset strobe", {31'd0, rf_wr_en}, 32'd0);

        // R4 R1 R3: identity word low octet first, then R8 zero fill past length 4
        do_read(6'd0, 1'b0, 7'd0, 6, "R4 R8 identity read");
        // R2: indexed start at byte 2 of file 0
        do_read(6'd0, 1'b1, 7'd2, 3, "R2 R8 indexed identity read");
        chk(rf_id == 6'd0, "R1 file select", {26'd0, rf_id}, 32'd0);

        // R6 R5 writes, plain and indexed
        do_write(6'd1, 1'b0, 7'd0, 3, 8'h11);
        do_write(6'd1, 1'b1, 7'd10, 2, 8'hC3);
        chk(rf_id == 6'd1, "R1 file select write", {26'd0, rf_id}, 32'd1);
        chk(rf_idx == 7'd12, "R5 index after indexed write", {25'd0, rf_idx}, 32'd12);
        do_read(6'd1, 1'b1, 7'd0, 3, "R5 readback of plain write");
        do_read(6'd1, 1'b1, 7'd9, 8, "R8 readback across length");

        // R7: read-only targets
        do_write(6'd0, 1'b0, 7'd0, 2, 8'h77);
        do_write(6'd2, 1'b1, 7'd1, 3, 8'h99);
        chk(rf_idx == 7'd4, "R5 index advance on discarded write", {25'd0, rf_idx}, 32'd4);
        do_read(6'd2, 1'b0, 7'd0, 5, "R7 read-only file unchanged");
        do_read(6'd0, 1'b0, 7'd0, 4, "R7 identity unchanged");

        // R10: extended header
        txb.delete();
        txb.push_back(8'hC1);
        txb.push_back(8'h85);
        txb.push_back(8'h3C);
        txb.push_back(8'hE1);
        spi_txn(0);
        chk(err_end == 1'b1, "R10 err raised", {31'd0, err_end}, 32'd1);
        foreach (rxb[k]) chk(rxb[k] == 8'h00, "R10 miso quiet", {24'd0, rxb[k]}, 32'd0);
        chk(err == 1'b1, "R10 err held after deselect", {31'd0, err}, 32'd1);
        do_read(6'd3, 1'b0, 7'd0, 2, "R8 zero-length file");
        chk(err_start == 1'b0, "R10 err cleared on select", {31'd0, err_start}, 32'd0);

        // R11: abort mid-octet then fresh transaction
        txb.delete();
        txb.push_back(8'hFF);
        spi_txn(3);
        do_read(6'd0, 1'b0, 7'd0, 4, "R11 parse after abort");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule